// File: doc/BRIEF.md
# Dual-Bank Complex PN Correlator

This block despreads a direct-sequence signal by correlating complex baseband samples against a programmable ternary spreading code. In-phase and quadrature samples arrive at two samples per chip, each 3 bits wide. A front-end stage averages each sample with the one before it and rounds the result to a 3-bit half-integer code. The codes then feed a 64-tap delay line per channel. Adjacent taps sit two samples apart, so the filter spans 64 chips. A new correlation value is produced for every valid sample.

Two coefficient banks are held inside the block. The acquisition bank despreads the preamble symbol that opens each burst. The data bank despreads every symbol after that. The block leaves reset on the acquisition bank. It moves to the data bank when an external detector pulses `detect`, and returns to the acquisition bank on `burst_start`. Coefficients are written one tap at a time through a small write port. Taps can be switched off in seven groups. Each channel's sum is scaled by a 2-bit viewport select and saturated to 8 bits.

Top module: `dual_pn_correlator`

## Requirements
- R1: After reset, `corr_valid` is 0, both correlation outputs are 0, the acquisition bank is selected, all stored coefficients are 00 and every delay-line entry holds code 0.
- R2: With averaging active, the value s = current sample + previous valid sample of the same channel is mapped to a 3-bit code c, where code c stands for c + 0.5. For s ≥ 0, c = floor(s/2). For s < 0, c = floor((s−1)/2). The result is clamped to the range −4..3. An even s is therefore rounded away from zero, the same way for both signs.
- R3: When `avg_bypass` is 1, the code equals the current sample. The previous-sample register still updates.
- R4: Tap 0 sees the newest code. Tap k sees the code from 2k valid samples earlier.
- R5: Coefficient encoding is 00 = 0, 01 = +1, 11 = −1, and 10 = 0. Each channel's sum is Σ coef_k·(2c_k+1) over the enabled taps, held as 10 bits signed.
- R6: The bank used for a sample is the bank selected before that clock edge. `burst_start` selects the acquisition bank, `detect` selects the data bank, and `burst_start` wins when both are high.
- R7: Tap k belongs to group k/10, giving seven groups. When bit g of `grp_en` is 0, every tap in group g adds 0 to the sum.
- R8: The output equals the sum shifted arithmetically right by `view_sel` bits, then saturated to −128..127.
- R9: `corr_valid` is high one clock after a cycle with `smp_valid`, and is low otherwise. The correlation outputs change only one clock after a valid sample.
- R10: A write with `cw_en` high stores `cw_code` at tap `cw_addr` of bank `cw_bank` (0 = acquisition, 1 = data). The new value is used from the next clock edge. The other bank is not touched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_valid | input | 1 | Sample strobe, two per chip |
| smp_i | input | 3 | In-phase sample, two's complement |
| smp_q | input | 3 | Quadrature sample, two's complement |
| avg_bypass | input | 1 | 1 = skip the averaging stage |
| view_sel | input | 2 | Output right-shift amount |
| grp_en | input | 7 | Enable for each tap group |
| burst_start | input | 1 | Select acquisition bank |
| detect | input | 1 | Select data bank |
| cw_en | input | 1 | Coefficient write strobe |
| cw_bank | input | 1 | Bank to write, 0 acquisition, 1 data |
| cw_addr | input | 6 | Tap index to write |
| cw_code | input | 2 | 2-bit coefficient code |
| corr_valid | output | 1 | Correlation outputs updated |
| corr_i | output | 8 | In-phase correlation, saturated |
| corr_q | output | 8 | Quadrature correlation, saturated |

## Verification
The bench drives both channels to full-scale constants. This pushes the sum to ±448, so the viewport must saturate at shifts 0 and 1. A missing clamp would wrap the output instead. Negative sums shifted by a non-power of two (−378 at shift 3 gives −48) catch a viewport that truncates toward zero instead of flooring.

Sample pairs with even negative and even positive sums expose rounding that is not symmetric. Single impulses with only tap 1 set check the two-sample tap spacing; a design that used one-sample spacing would show the impulse a sample early. Simultaneous `detect` and `burst_start` check the bank priority, and a `detect` arriving on a sample cycle shows whether a bank change leaks into the current sample. Writes to the idle bank and the unused code 10 must leave the output unchanged.

// File: rtl/pnmf_pkg.sv
package pnmf_pkg;
    localparam int FE_W = 3;
    localparam int COEF_W = 2;

    typedef logic [FE_W-1:0] fe_code_t;
    typedef logic [COEF_W-1:0] coef_t;

    localparam coef_t COEF_POS = 2'b01;
    localparam coef_t COEF_NEG = 2'b11;
endpackage

// File: rtl/pnmf_frontend.sv
module pnmf_frontend #(
    parameter int SW = 3
) (
    input  logic signed [SW-1:0]    smp,
    input  logic signed [SW-1:0]    prev,
    input  logic                    bypass,
    output pnmf_pkg::fe_code_t      code
);
    localparam int XW = SW + 2;
    localparam logic signed [XW-1:0] HI = XW'(2 ** (pnmf_pkg::FE_W - 1) - 1);
    localparam logic signed [XW-1:0] LO = -XW'(2 ** (pnmf_pkg::FE_W - 1));

    logic signed [XW-1:0] smp_x, prev_x, s_sum, s_m1, r_val;

    always_comb begin
        smp_x  = {{2{smp[SW-1]}}, smp};
        prev_x = {{2{prev[SW-1]}}, prev};
        s_sum  = smp_x + prev_x;
        s_m1   = s_sum - {{(XW-1){1'b0}}, 1'b1};
        if (bypass) begin
            r_val = smp_x;
        end else if (!s_sum[XW-1]) begin
            r_val = s_sum >>> 1;
        end else begin
            r_val = s_m1 >>> 1;
        end
        if (r_val > HI) begin
            code = HI[pnmf_pkg::FE_W-1:0];
        end else if (r_val < LO) begin
            code = LO[pnmf_pkg::FE_W-1:0];
        end else begin
            code = r_val[pnmf_pkg::FE_W-1:0];
        end
    end
endmodule

// File: rtl/pnmf_coef_bank.sv
module pnmf_coef_bank #(
    parameter int NTAPS = 64,
    localparam int AW = $clog2(NTAPS)
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                wr_en,
    input  logic                                wr_bank,
    input  logic [AW-1:0]                       wr_addr,
    input  pnmf_pkg::coef_t                     wr_code,
    input  logic                                rd_bank,
    output logic [NTAPS-1:0][pnmf_pkg::COEF_W-1:0] coefs
);
    logic [1:0][NTAPS-1:0][pnmf_pkg::COEF_W-1:0] mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        if (wr_en) begin
            mem_d[wr_bank][wr_addr] = wr_code;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_q <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    assign coefs = mem_q[rd_bank];
endmodule

// File: rtl/pnmf_viewport.sv
module pnmf_viewport #(
    parameter int IW = 10,
    parameter int OW = 8,
    parameter int SELW = 2
) (
    input  logic signed [IW-1:0]  sum_in,
    input  logic [SELW-1:0]       sel,
    output logic [OW-1:0]         win_out
);
    localparam logic signed [IW-1:0] OMAX = IW'(2 ** (OW - 1) - 1);
    localparam logic signed [IW-1:0] OMIN = -IW'(2 ** (OW - 1));

    logic signed [IW-1:0] shifted;

    always_comb begin
        shifted = sum_in >>> sel;
        if (shifted > OMAX) begin
            win_out = OMAX[OW-1:0];
        end else if (shifted < OMIN) begin
            win_out = OMIN[OW-1:0];
        end else begin
            win_out = shifted[OW-1:0];
        end
    end
endmodule

// File: rtl/dual_pn_correlator.sv
module dual_pn_correlator #(
    parameter int NTAPS  = 64,
    parameter int SW     = 3,
    parameter int NGRP   = 7,
    parameter int SUM_W  = 10,
    parameter int OUT_W  = 8,
    parameter int VSEL_W = 2,
    localparam int AW       = $clog2(NTAPS),
    localparam int GRP_SZ   = (NTAPS + NGRP - 1) / NGRP,
    localparam int LINE_LEN = 2 * NTAPS - 1,
    localparam int CW       = pnmf_pkg::FE_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  smp_valid,
    input  logic signed [SW-1:0]  smp_i,
    input  logic signed [SW-1:0]  smp_q,
    input  logic                  avg_bypass,
    input  logic [VSEL_W-1:0]     view_sel,
    input  logic [NGRP-1:0]       grp_en,
    input  logic                  burst_start,
    input  logic                  detect,
    input  logic                  cw_en,
    input  logic                  cw_bank,
    input  logic [AW-1:0]         cw_addr,
    input  logic [1:0]            cw_code,
    output logic                  corr_valid,
    output logic [OUT_W-1:0]      corr_i,
    output logic [OUT_W-1:0]      corr_q
);
    typedef struct packed {
        logic [LINE_LEN-1:0][CW-1:0] line_i;
        logic [LINE_LEN-1:0][CW-1:0] line_q;
        logic [SW-1:0]               prev_i;
        logic [SW-1:0]               prev_q;
        logic                        bank;
        logic                        vld;
        logic [OUT_W-1:0]            out_i;
        logic [OUT_W-1:0]            out_q;
    } corr_st_t;

    corr_st_t st_d, st_q;

    logic [NTAPS-1:0][pnmf_pkg::COEF_W-1:0] coefs;
    pnmf_pkg::fe_code_t code_i, code_q;
    logic [LINE_LEN-1:0][CW-1:0] shl_i, shl_q;
    logic signed [SUM_W-1:0] sum_i, sum_q;
    logic [OUT_W-1:0] vp_i, vp_q;
    logic bank_sel;

    assign bank_sel = st_q.bank;

    pnmf_coef_bank #(.NTAPS(NTAPS)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(cw_en), .wr_bank(cw_bank),
        .wr_addr(cw_addr), .wr_code(cw_code), .rd_bank(st_q.bank), .coefs(coefs)
    );

    pnmf_frontend #(.SW(SW)) u_fe_i (
        .smp(smp_i), .prev(st_q.prev_i), .bypass(avg_bypass), .code(code_i)
    );

    pnmf_frontend #(.SW(SW)) u_fe_q (
        .smp(smp_q), .prev(st_q.prev_q), .bypass(avg_bypass), .code(code_q)
    );

    always_comb begin
        if (smp_valid) begin
            shl_i = {st_q.line_i[LINE_LEN-2:0], code_i};
            shl_q = {st_q.line_q[LINE_LEN-2:0], code_q};
        end else begin
            shl_i = st_q.line_i;
            shl_q = st_q.line_q;
        end
    end

    // Taps read every second delay-line entry; disabled groups contribute nothing.
    always_comb begin
        logic signed [CW:0] tv_i, tv_q;
        sum_i = '0;
        sum_q = '0;
        for (int k = 0; k < NTAPS; k++) begin
            tv_i = $signed({shl_i[2*k], 1'b1});
            tv_q = $signed({shl_q[2*k], 1'b1});
            if (grp_en[k / GRP_SZ]) begin
                if (coefs[k] == pnmf_pkg::COEF_POS) begin
                    sum_i = sum_i + {{(SUM_W-CW-1){tv_i[CW]}}, tv_i};
                    sum_q = sum_q + {{(SUM_W-CW-1){tv_q[CW]}}, tv_q};
                end else if (coefs[k] == pnmf_pkg::COEF_NEG) begin
                    sum_i = sum_i - {{(SUM_W-CW-1){tv_i[CW]}}, tv_i};
                    sum_q = sum_q - {{(SUM_W-CW-1){tv_q[CW]}}, tv_q};
                end
            end
        end
    end

    pnmf_viewport #(.IW(SUM_W), .OW(OUT_W), .SELW(VSEL_W)) u_vp_i (
        .sum_in(sum_i), .sel(view_sel), .win_out(vp_i)
    );

    pnmf_viewport #(.IW(SUM_W), .OW(OUT_W), .SELW(VSEL_W)) u_vp_q (
        .sum_in(sum_q), .sel(view_sel), .win_out(vp_q)
    );

    always_comb begin
        st_d = st_q;
        st_d.vld = smp_valid;
        st_d.line_i = shl_i;
        st_d.line_q = shl_q;
        if (smp_valid) begin
            st_d.prev_i = smp_i;
            st_d.prev_q = smp_q;
            st_d.out_i  = vp_i;
            st_d.out_q  = vp_q;
        end
        if (burst_start) begin
            st_d.bank = 1'b0;
        end else if (detect) begin
            st_d.bank = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign corr_valid = st_q.vld;
    assign corr_i     = st_q.out_i;
    assign corr_q     = st_q.out_q;
endmodule

// File: rtl/pnmf_corr_chk.sv
module pnmf_corr_chk #(
    parameter int NTAPS = 64,
    parameter int OUT_W = 8,
    parameter int VSEL_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              smp_valid,
    input logic              burst_start,
    input logic              detect,
    input logic [VSEL_W-1:0] view_sel,
    input logic              corr_valid,
    input logic [OUT_W-1:0]  corr_i,
    input logic [OUT_W-1:0]  corr_q,
    input logic              bank_sel
);
    localparam int MAXV = (NTAPS * 7) / 8;
    localparam logic [VSEL_W-1:0] SEL_TOP = '1;

    a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |=> corr_valid);

    a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> (!corr_valid && $stable(corr_i) && $stable(corr_q)));

    a_r6_burst_start_wins: assert property (@(posedge clk) disable iff (!rst_n)
        burst_start |=> !bank_sel);

    a_r6_detect_selects_data: assert property (@(posedge clk) disable iff (!rst_n)
        (detect && !burst_start) |=> bank_sel);

    a_r8_widest_shift_range: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && view_sel == SEL_TOP) |=>
        ($signed(corr_i) <= MAXV && $signed(corr_i) >= -MAXV &&
         $signed(corr_q) <= MAXV && $signed(corr_q) >= -MAXV));
endmodule

bind dual_pn_correlator pnmf_corr_chk #(.NTAPS(NTAPS), .OUT_W(OUT_W), .VSEL_W(VSEL_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .burst_start(burst_start),
    .detect(detect), .view_sel(view_sel), .corr_valid(corr_valid),
    .corr_i(corr_i), .corr_q(corr_q), .bank_sel(bank_sel)
);

// File: tb/dual_pn_correlator_tb.sv
module dual_pn_correlator_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic smp_valid = 1'b0;
    logic signed [2:0] smp_i = '0, smp_q = '0;
    logic avg_bypass = 1'b0;
    logic [1:0] view_sel = '0;
    logic [6:0] grp_en = '1;
    logic burst_start = 1'b0, detect = 1'b0;
    logic cw_en = 1'b0, cw_bank = 1'b0;
    logic [5:0] cw_addr = '0;
    logic [1:0] cw_code = '0;
    logic corr_valid;
    logic [7:0] corr_i, corr_q;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    dual_pn_correlator dut_i (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_i(smp_i), .smp_q(smp_q),
        .avg_bypass(avg_bypass), .view_sel(view_sel), .grp_en(grp_en),
        .burst_start(burst_start), .detect(detect), .cw_en(cw_en), .cw_bank(cw_bank),
        .cw_addr(cw_addr), .cw_code(cw_code), .corr_valid(corr_valid),
        .corr_i(corr_i), .corr_q(corr_q)
    );

    // ---------------- behavioural reference model ----------------
    int hist_i[127], hist_q[127];
    int cf[2][64];
    int prev_i, prev_q, bank;
    int exp_i, exp_q, exp_v;

    function automatic int fe_code(int x, int p, bit byp);
        int s, r;
        if (byp) r = x;
        else begin
            s = x + p;
            if (s >= 0) r = s / 2;
            else r = -((-s + 2) / 2);
        end
        if (r > 3) r = 3;
        if (r < -4) r = -4;
        return r;
    endfunction

    function automatic int decode(logic [1:0] c);
        if (c == 2'b01) return 1;
        if (c == 2'b11) return -1;
        return 0;
    endfunction

    function automatic int window(int s, int sel);
        int v = s;
        for (int n = 0; n < sel; n++) v = (v >= 0) ? v / 2 : -((-v + 1) / 2);
        if (v > 127) v = 127;
        if (v < -128) v = -128;
        return v;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (hist_i[j]) begin hist_i[j] = 1; hist_q[j] = 1; end
            foreach (cf[b, k]) cf[b][k] = 0;
            prev_i = 0; prev_q = 0; bank = 0;
            exp_i = 0; exp_q = 0; exp_v = 0;
        end else begin
            exp_v = smp_valid;
            if (smp_valid) begin
                int si, sq;
                for (int j = 126; j > 0; j--) begin
                    hist_i[j] = hist_i[j-1];
                    hist_q[j] = hist_q[j-1];
                end
                hist_i[0] = 2 * fe_code(int'(smp_i), prev_i, avg_bypass) + 1;
                hist_q[0] = 2 * fe_code(int'(smp_q), prev_q, avg_bypass) + 1;
                prev_i = int'(smp_i);
                prev_q = int'(smp_q);
                si = 0; sq = 0;
                for (int k = 0; k < 64; k++) begin
                    if (grp_en[k / 10]) begin
                        si += cf[bank][k] * hist_i[2*k];
                        sq += cf[bank][k] * hist_q[2*k];
                    end
                end
                exp_i = window(si, int'(view_sel));
                exp_q = window(sq, int'(view_sel));
            end
            if (burst_start) bank = 0;
            else if (detect) bank = 1;
            if (cw_en) cf[cw_bank][cw_addr] = decode(cw_code);
        end
    end

    task automatic check(string tag, int act, int expv);
        n_checks++;
        if (act != expv) begin
            n_errors++;
            $display("FAIL %s: got %0d expected %0d", tag, act, expv);
        end
    endtask

    // every-cycle comparison against the model (R5 R9)
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check("R9 corr_valid", int'(corr_valid), exp_v);
            check("R5 corr_i model", int'($signed(corr_i)), exp_i);
            check("R5 corr_q model", int'($signed(corr_q)), exp_q);
        end
    end

    // ---------------- stimulus ----------------
    task automatic send(int vi, int vq);
        smp_valid = 1'b1; smp_i = 3'(vi); smp_q = 3'(vq);
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic wr(bit b, int a, logic [1:0] c);
        cw_en = 1'b1; cw_bank = b; cw_addr = 6'(a); cw_code = c;
        @(negedge clk);
        cw_en = 1'b0;
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    task automatic fill(int vi, int vq, int n);
        for (int k = 0; k < n; k++) send(vi, vq);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle();
        // R1: reset state
        check("R1 valid after reset", int'(corr_valid), 0);
        check("R1 corr_i after reset", int'(corr_i), 0);
        check("R1 corr_q after reset", int'(corr_q), 0);
        send(0, 0);
        check("R1 empty banks give zero", int'($signed(corr_i)), 0);

        for (int k = 0; k < 64; k++) wr(1'b0, k, 2'b01);
        wr(1'b1, 0, 2'b11);

        // R8: full-scale sums at each shift
        fill(3, -4, 130);
        check("R8 sel0 sat high", int'($signed(corr_i)), 127);
        check("R8 sel0 sat low", int'($signed(corr_q)), -128);
        view_sel = 2'd1; send(3, -4);
        check("R8 sel1 sat high", int'($signed(corr_i)), 127);
        check("R8 sel1 sat low", int'($signed(corr_q)), -128);
        view_sel = 2'd2; send(3, -4);
        check("R8 sel2", int'($signed(corr_i)), 112);
        check("R8 sel2 neg", int'($signed(corr_q)), -112);
        view_sel = 2'd3; send(3, -4);
        check("R8 sel3", int'($signed(corr_i)), 56);
        check("R8 sel3 neg", int'($signed(corr_q)), -56);

        // R7: disable group 0 (taps 0..9)
        grp_en = 7'b1111110; send(3, -4);
        check("R7 group0 off sel3", int'($signed(corr_i)), 47);
        check("R7 group0 off sel3 floor", int'($signed(corr_q)), -48);
        view_sel = 2'd2; send(3, -4);
        check("R7 group0 off sel2", int'($signed(corr_i)), 94);
        check("R7 group0 off sel2 neg", int'($signed(corr_q)), -95);
        grp_en = 7'b1111111; view_sel = 2'd0;

        // R6: detect on a sample cycle applies from the next sample
        detect = 1'b1; send(3, -4); detect = 1'b0;
        check("R6 old bank on detect cycle", int'($signed(corr_i)), 127);
        send(3, -4);
        check("R6 data bank i", int'($signed(corr_i)), -7);
        check("R6 data bank q", int'($signed(corr_q)), 7);

        // R10: writing idle bank leaves output alone
        wr(1'b0, 1, 2'b11); send(3, -4);
        check("R10 idle bank write", int'($signed(corr_i)), -7);
        wr(1'b0, 1, 2'b01);

        // R5: code 10 is zero
        wr(1'b1, 1, 2'b10); send(3, -4);
        check("R5 code 10 is zero", int'($signed(corr_i)), -7);

        // R3: bypass passes sample as code
        avg_bypass = 1'b1; send(2, -4);
        check("R3 bypass i", int'($signed(corr_i)), -5);
        check("R3 bypass q", int'($signed(corr_q)), 7);

        // R4: only tap 1 set, impulse shows after two samples
        wr(1'b1, 0, 2'b00); wr(1'b1, 1, 2'b01);
        fill(0, 0, 3);
        send(3, -4);
        check("R4 impulse not yet at tap1", int'($signed(corr_i)), 1);
        send(0, 0);
        check("R4 impulse one sample later", int'($signed(corr_i)), 1);
        send(0, 0);
        check("R4 impulse at tap1 i", int'($signed(corr_i)), 7);
        check("R4 impulse at tap1 q", int'($signed(corr_q)), -7);

        // R2: averaging and symmetric rounding, only tap0 = -1
        avg_bypass = 1'b0; wr(1'b1, 1, 2'b00); wr(1'b1, 0, 2'b11);
        send(2, 2); send(-3, -3);
        check("R2 odd negative sum", int'($signed(corr_i)), 1);
        send(-1, -1); send(-1, -1);
        check("R2 even negative rounds away", int'($signed(corr_i)), 3);
        send(1, 1); send(1, 1);
        check("R2 even positive rounds away", int'($signed(corr_q)), -3);
        send(3, 3); send(3, 3);
        check("R2 top of range", int'($signed(corr_i)), -7);
        send(-4, -4); send(-4, -4);
        check("R2 clamp at bottom", int'($signed(corr_i)), 7);

        // R6: both strobes at once, burst_start wins
        burst_start = 1'b1; detect = 1'b1; idle(); burst_start = 1'b0; detect = 1'b0;
        fill(3, 3, 130);
        check("R6 burst_start priority", int'($signed(corr_i)), 127);

        // mixed traffic against the model
        for (int n = 0; n < 3000; n++) begin
            smp_valid = ($urandom_range(0, 3) != 0);
            smp_i = 3'($urandom_range(0, 7));
            smp_q = 3'($urandom_range(0, 7));
            avg_bypass = ($urandom_range(0, 7) == 0);
            view_sel = 2'($urandom_range(0, 3));
            grp_en = ($urandom_range(0, 3) == 0) ? 7'($urandom_range(0, 127)) : 7'h7f;
            detect = ($urandom_range(0, 40) == 0);
            burst_start = ($urandom_range(0, 60) == 0);
            cw_en = ($urandom_range(0, 2) == 0);
            cw_bank = 1'($urandom_range(0, 1));
            cw_addr = 6'($urandom_range(0, 63));
            cw_code = 2'($urandom_range(0, 3));
            @(negedge clk);
        end
        smp_valid = 1'b0; cw_en = 1'b0; detect = 1'b0; burst_start = 1'b0;
        idle();
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: got %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end
endmodule